// File: doc/BRIEF.md
# Sideband Command Controller Register Stub

This block is a memory-mapped register file that stands in for a processor-sideband command controller. It does not drive any wire to a remote device. Firmware talks to it over a simple 32-bit register bus: a byte address, a write enable, write data, and combinational read data. One level-sensitive interrupt output signals the end of a command.

Firmware sets up registers and then writes the start bit to launch a command. The block finishes every accepted command at once. It writes the success completion code 0x40 into the first words of both data buffers. It then records a done flag, gated by an enable mask, and uses that flag to raise the interrupt. Firmware acknowledges the interrupt by writing ones to the status register. Every other implemented word behaves as plain storage, so driver set-up writes read back as written.

Top module: `sideband_ctl_stub`

## Requirements
- R1: After reset, every implemented word reads zero and `irq` is low.
- R2: Byte offset 0x08 is the command word. Its bit 0 is the start bit. Nothing written there is stored, and a read of 0x08 always returns zero.
- R3: A write to 0x08 with bit 0 set is accepted when the status word (0x1C) is zero. An accepted write loads 0x40 into the word at 0x20 and into the word at 0x30.
- R4: An accepted start sets the status word to the value of the enable mask word (0x18) ANDed with 0x1. Bit 0 of the status word means done.
- R5: A start write that arrives while the status word is nonzero is refused. The buffers and the status word keep their values.
- R6: The status word is write-one-to-clear. Once a write leaves it at zero, `irq` is low from the next cycle onward.
- R7: A status write that leaves any status bit set keeps `irq` high.
- R8: A write to 0x08 with bit 0 clear has no effect.
- R9: Every other word-aligned offset from 0x00 through 0x5C is read/write storage.
- R10: At offsets 0x60 and above, and at addresses that are not word-aligned, writes are dropped and reads return zero.
- R11: `irq` is registered. It rises in the cycle after the accepted start write, never during that write's cycle. It stays high until the status word is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Command-done interrupt, level-sensitive |

## Verification
The bench builds the block with its default parameters: 32-bit words, 24 implemented words, and a 12-bit byte address. With these values both edges of the decoded range can be reached: the last storage word at 0x5C and the first dropped offset at 0x60. Misaligned byte addresses inside the range can be reached as well. The default placement of the command, mask, status and buffer words lets the bench run the full flow with directed writes. The flow covers a masked start, an unmasked start, a start refused while status is pending, a partial acknowledge, and a full acknowledge.

// File: rtl/sideband_ctl_stub.sv
module sideband_ctl_stub #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 24,
  parameter int ADDR_W    = 12,
  parameter int CMD_IDX   = 2,
  parameter int IEN_IDX   = 6,
  parameter int STS_IDX   = 7,
  parameter int WBUF_IDX  = 8,
  parameter int RBUF_IDX  = 12,
  parameter logic [DATA_W-1:0] DONE_CODE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int IDX_W   = ADDR_W - BYTE_SH;
  localparam int SLOT_W  = $clog2(NUM_WORDS);
  localparam logic [IDX_W-1:0]  LIMIT  = IDX_W'(NUM_WORDS);
  localparam logic [SLOT_W-1:0] S_CMD  = SLOT_W'(CMD_IDX);
  localparam logic [SLOT_W-1:0] S_STS  = SLOT_W'(STS_IDX);
  localparam logic [DATA_W-1:0] DONE_BIT = 1;

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [IDX_W-1:0]  word_idx;
  logic [SLOT_W-1:0] slot;
  logic              hit, wr_hit, fire_ok, irq_q;
  logic [DATA_W-1:0] sts_cur, ien_cur, sts_nxt;

  assign word_idx = bus_addr[ADDR_W-1:BYTE_SH];
  assign slot     = word_idx[SLOT_W-1:0];
  assign hit      = (bus_addr[BYTE_SH-1:0] == '0) && (word_idx < LIMIT);
  assign wr_hit   = bus_wen && hit;
  assign sts_cur  = mem[STS_IDX];
  assign ien_cur  = mem[IEN_IDX];
  assign fire_ok  = wr_hit && (slot == S_CMD) && bus_wdata[0] && (sts_cur == '0);

  assign bus_rdata = (hit && slot != S_CMD) ? mem[slot] : '0;
  assign irq = irq_q;

  always_comb begin
    sts_nxt = sts_cur;
    if (wr_hit && slot == S_STS) sts_nxt = sts_cur & ~bus_wdata;
    if (fire_ok)                 sts_nxt = ien_cur & DONE_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_hit && slot != S_CMD && slot != S_STS) mem[slot] <= bus_wdata;
      if (fire_ok) begin
        mem[WBUF_IDX] <= DONE_CODE;
        mem[RBUF_IDX] <= DONE_CODE;
      end
      mem[STS_IDX] <= sts_nxt;
      irq_q <= |sts_nxt;
    end
  end
endmodule

// File: rtl/sideband_ctl_stub_chk.sv
module sideband_ctl_stub_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h08,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] LIMIT    = 'h60
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] sts,
  input logic [DATA_W-1:0] ien
);
  a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == CMD_ADDR |-> bus_rdata == '0);

  a_r10_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr >= LIMIT |-> bus_rdata == '0);

  a_r4_done_masked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == CMD_ADDR && bus_wdata[0] && sts == '0
    |=> sts == ($past(ien) & DATA_W'(1)));

  a_r5_fire_refused: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == CMD_ADDR && sts != '0 |=> $stable(sts) && irq);

  a_r6_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == STS_ADDR && (sts & ~bus_wdata) == '0 |=> !irq);

  a_r7_partial_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == STS_ADDR && (sts & ~bus_wdata) != '0 |=> irq);

  a_r11_irq_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wen && bus_addr == CMD_ADDR && bus_wdata[0]));
endmodule

bind sideband_ctl_stub sideband_ctl_stub_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .sts(sts_cur), .ien(ien_cur)
);

// File: tb/sideband_ctl_stub_bench.sv
`timescale 1ns/1ps
module sideband_ctl_stub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sideband_ctl_stub u_sideband_ctl_stub (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h018, 32'h0,        4'd1},  // R1 mask word clear
    '{1'b0, 12'h01C, 32'h0,        4'd1},  // R1 status clear
    '{1'b0, 12'h030, 32'h0,        4'd1},  // R1 buffer clear
    '{1'b1, 12'h000, 32'hA5A5_0F0F, 4'd9}, // R9 first word
    '{1'b0, 12'h000, 32'hA5A5_0F0F, 4'd9},
    '{1'b1, 12'h05C, 32'h1234_5678, 4'd9}, // R9 last word
    '{1'b0, 12'h05C, 32'h1234_5678, 4'd9},
    '{1'b1, 12'h044, 32'hDEAD_BEEF, 4'd9},
    '{1'b0, 12'h044, 32'hDEAD_BEEF, 4'd9},
    '{1'b1, 12'h060, 32'hFFFF_FFFF, 4'd10}, // R10 beyond range
    '{1'b0, 12'h060, 32'h0,        4'd10},
    '{1'b0, 12'hFFC, 32'h0,        4'd10},
    '{1'b1, 12'h002, 32'h0000_0077, 4'd10}, // R10 misaligned
    '{1'b0, 12'h000, 32'hA5A5_0F0F, 4'd10},
    '{1'b0, 12'h002, 32'h0,        4'd10},
    '{1'b1, 12'h008, 32'hFFFF_FFFE, 4'd8},  // R8 no start bit
    '{1'b0, 12'h020, 32'h0,        4'd8},
    '{1'b0, 12'h01C, 32'h0,        4'd8},
    '{1'b0, 12'h008, 32'h0,        4'd2},   // R2 command reads zero
    '{1'b1, 12'h008, 32'h0000_0001, 4'd4},  // R4 start with mask clear
    '{1'b0, 12'h01C, 32'h0,        4'd4},
    '{1'b0, 12'h030, 32'h0000_0040, 4'd3}   // R3 code loaded
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
    #0.5;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int req);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check(1, 32'(irq), 32'h0); // R1 irq low

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
    end
    check(4, 32'(irq), 32'h0); // R4 masked start leaves irq low

    // R3 R4 R11: unmasked start
    wr(12'h018, 32'h0000_0001);
    wr(12'h020, 32'h0);
    wr(12'h030, 32'h0);
    @(negedge clk);
    bus_addr = 12'h008; bus_wdata = 32'h1; bus_wen = 1'b1;
    #0.5;
    check(11, 32'(irq), 32'h0);   // R11 not during the write cycle
    @(negedge clk);
    bus_wen = 1'b0;
    #0.5;
    check(11, 32'(irq), 32'h1);   // R11 high the next cycle
    rd(12'h01C, 32'h1, 4);        // R4 done bit
    rd(12'h020, 32'h40, 3);       // R3
    rd(12'h030, 32'h40, 3);       // R3
    rd(12'h008, 32'h0, 2);        // R2

    // R5: refused while pending
    wr(12'h020, 32'h0000_0055);
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h55, 5);
    rd(12'h01C, 32'h1, 5);
    check(5, 32'(irq), 32'h1);

    // R7: partial clear
    wr(12'h01C, 32'hFFFF_FFFE);
    check(7, 32'(irq), 32'h1);
    rd(12'h01C, 32'h1, 7);

    // R6: full clear
    wr(12'h01C, 32'h1);
    check(6, 32'(irq), 32'h0);
    rd(12'h01C, 32'h0, 6);

    // R3: accepted again after clear
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h40, 3);
    check(11, 32'(irq), 32'h1);

    // R1: reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    check(1, 32'(irq), 32'h0);
    rd(12'h000, 32'h0, 1);
    rd(12'h018, 32'h0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule